// File: doc/BRIEF.md
# Signed Adder-Subtractor with Overflow

This block is a purely combinational two's complement adder/subtractor. Its width is set by a parameter. A chain of full-adder cells does the work, and the carry ripples from the least significant cell to the most significant one. One select input picks the operation, and the same adder serves both. For subtraction, every bit of the second operand is inverted and the select itself feeds a one into the bottom cell's carry input, so the chain computes A + ~B + 1.

The block has three outputs:
- the wrapped n-bit result;
- the raw carry out of the top cell, which is the unsigned carry for addition and the not-borrow for subtraction;
- a signed overflow flag, kept separate from the raw carry.

Overflow is raised when the two values entering the adder share a sign and the result's sign differs from it. In subtract mode the second of those values is the inverted operand. The flag therefore marks exactly the cases where the true signed sum or difference falls outside the range -2^(n-1) to 2^(n-1)-1.

The block has no clock and no state. No state machine is present, so the brief names no states or transitions.

Top module: `addsub_ovf_top`

## Requirements
- R1: With op_sub = 0, result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R2: With op_sub = 1, result equals (opnd_a - opnd_b) modulo 2^WIDTH.
- R3: With op_sub = 0, carry_out equals bit WIDTH of the unsigned sum opnd_a + opnd_b.
- R4: With op_sub = 1, carry_out is 1 exactly when opnd_a >= opnd_b as unsigned numbers (no borrow).
- R5: With op_sub = 0, overflow is 1 exactly when the signed sum of the operands lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R6: With op_sub = 1, overflow is 1 exactly when the signed difference opnd_a - opnd_b lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R7: With op_sub = 0, overflow is never 1 when the most significant bits of the two operands differ.
- R8: At WIDTH = 4, adding 0111 and 0100 gives result 1011 with overflow 1. Adding 1100 and 1010 gives result 0110 with overflow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sub | input | 1 | Operation select: 0 adds, 1 subtracts |
| opnd_a | input | WIDTH | First operand, two's complement |
| opnd_b | input | WIDTH | Second operand, two's complement |
| result | output | WIDTH | Wrapped sum or difference |
| carry_out | output | 1 | Carry out of the top cell (not-borrow when subtracting) |
| overflow | output | 1 | Signed overflow flag |

## Verification
All three outputs are combinational, so each result is due in the same cycle its operands and select are applied, with zero register stages between them. The bench drives new inputs just after a falling clock edge and samples the outputs one time unit later, well before the next rising edge. This lets the ripple chain settle before any comparison is made. At WIDTH = 4, every operand pair is swept in both modes and checked against integer arithmetic. A 16-bit instance is checked at boundary values and along a pseudo-random walk.

// File: rtl/addsub_ovf_pkg.sv
package addsub_ovf_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    // Overflow detector variant selection
    typedef enum int {
        OVF_BY_SIGNS  = 0,
        OVF_BY_CARRIES = 1
    } ovf_style_e;

endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    always_comb begin
        s_out = x_in ^ y_in ^ c_in;
        c_out = (x_in & y_in) | (x_in & c_in) | (y_in & c_in);
    end

endmodule

// File: rtl/addsub_ripple_chain.sv
module addsub_ripple_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             c_low,
    output logic [WIDTH-1:0] s_vec,
    output logic             c_top,
    output logic             c_into_sign
);

    localparam int SIGN_IDX = WIDTH - 1;

    logic [WIDTH:0] carry_w;

    assign carry_w[0] = c_low;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        addsub_fa_cell u_fa (
            .x_in  (x_vec[gi]),
            .y_in  (y_vec[gi]),
            .c_in  (carry_w[gi]),
            .s_out (s_vec[gi]),
            .c_out (carry_w[gi+1])
        );
    end

    assign c_top       = carry_w[WIDTH];
    assign c_into_sign = carry_w[SIGN_IDX];

endmodule

// File: rtl/addsub_ovf_detect.sv
module addsub_ovf_detect #(
    parameter int STYLE = 0
) (
    input  logic sign_x,
    input  logic sign_y_eff,
    input  logic sign_s,
    input  logic c_into_sign,
    input  logic c_top,
    output logic ovf
);

    if (STYLE == 1) begin : g_carry_style
        assign ovf = c_into_sign ^ c_top;
    end else begin : g_sign_style
        logic same_sign_w;
        assign same_sign_w = ~(sign_x ^ sign_y_eff);
        assign ovf = same_sign_w & (sign_s ^ sign_x);
    end

endmodule

// File: rtl/addsub_ovf_top.sv
module addsub_ovf_top #(
    parameter int WIDTH     = 16,
    parameter int OVF_STYLE = 0
) (
    input  logic             op_sub,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);

    import addsub_ovf_pkg::*;

    localparam int MSB = WIDTH - 1;

    addsub_op_e      op_w;
    logic [MSB:0]    b_eff_w;
    logic            c_sign_w;
    logic            c_top_w;

    assign op_w    = addsub_op_e'(op_sub);
    assign b_eff_w = (op_w == OP_SUB) ? ~opnd_b : opnd_b;

    addsub_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .x_vec       (opnd_a),
        .y_vec       (b_eff_w),
        .c_low       (op_sub),
        .s_vec       (result),
        .c_top       (c_top_w),
        .c_into_sign (c_sign_w)
    );

    addsub_ovf_detect #(.STYLE(OVF_STYLE)) u_ovf (
        .sign_x      (opnd_a[MSB]),
        .sign_y_eff  (b_eff_w[MSB]),
        .sign_s      (result[MSB]),
        .c_into_sign (c_sign_w),
        .c_top       (c_top_w),
        .ovf         (overflow)
    );

    assign carry_out = c_top_w;

endmodule

// File: rtl/addsub_ovf_chk.sv
module addsub_ovf_chk #(
    parameter int WIDTH = 16
) (
    input logic             op_sub,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;
    logic [WIDTH:0] wide_diff;

    assign wide_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign wide_diff = {1'b0, opnd_a} - {1'b0, opnd_b};

    always @* begin
        if (!op_sub) begin
            AST_ADD_SUM: assert (result == wide_sum[MSB:0]); // R1
            AST_ADD_CARRY: assert (carry_out == wide_sum[WIDTH]); // R3
            AST_NO_OVF_MIXED: assert (!(opnd_a[MSB] != opnd_b[MSB] && overflow)); // R7
            AST_ADD_OVF: assert (overflow == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))); // R5
        end else begin
            AST_SUB_DIFF: assert (result == wide_diff[MSB:0]); // R2
            AST_SUB_NOBORROW: assert (carry_out == (opnd_a >= opnd_b)); // R4
            AST_SUB_OVF: assert (overflow == ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))); // R6
        end
    end

endmodule

bind addsub_ovf_top addsub_ovf_chk #(.WIDTH(WIDTH)) u_chk (
    .op_sub    (op_sub),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/addsub_ovf_top_tb.sv
module addsub_ovf_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int WW = 16;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          n_sub;
    logic [NW-1:0] n_a, n_b, n_res;
    logic          n_c, n_v;
    logic          w_sub;
    logic [WW-1:0] w_a, w_b, w_res;
    logic          w_c, w_v;

    addsub_ovf_top #(.WIDTH(NW)) u_dut (
        .op_sub(n_sub), .opnd_a(n_a), .opnd_b(n_b),
        .result(n_res), .carry_out(n_c), .overflow(n_v)
    );

    addsub_ovf_top #(.WIDTH(WW), .OVF_STYLE(1)) u_dut_wide (
        .op_sub(w_sub), .opnd_a(w_a), .opnd_b(w_b),
        .result(w_res), .carry_out(w_c), .overflow(w_v)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Expected values from integer arithmetic
    task automatic model(input int w, input int a, input int b, input bit sub,
                         output int r, output int c, output int v);
        int mask, half, sa, sb, full;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        sa = (a >= half) ? a - (1 << w) : a;
        sb = (b >= half) ? b - (1 << w) : b;
        full = sub ? sa - sb : sa + sb;
        v = (full < -half || full > half - 1) ? 1 : 0;
        r = (sub ? a - b : a + b) & mask;
        c = sub ? ((a >= b) ? 1 : 0) : (((a + b) >> w) & 1);
    endtask

    task automatic run_narrow(input int a, input int b, input bit sub);
        int er, ec, ev;
        @(negedge clk);
        n_a = NW'(a); n_b = NW'(b); n_sub = sub;
        #1;
        model(NW, a, b, sub, er, ec, ev);
        if (!sub) begin
            chk("R1", "narrow sum", int'(n_res), er);
            chk("R3", "narrow carry", int'(n_c), ec);
            chk("R5", "narrow add ovf", int'(n_v), ev);
            if (n_a[NW-1] != n_b[NW-1]) chk("R7", "mixed-sign ovf", int'(n_v), 0);
        end else begin
            chk("R2", "narrow diff", int'(n_res), er);
            chk("R4", "narrow not-borrow", int'(n_c), ec);
            chk("R6", "narrow sub ovf", int'(n_v), ev);
        end
    endtask

    task automatic run_wide(input int a, input int b, input bit sub);
        int er, ec, ev;
        @(negedge clk);
        w_a = WW'(a); w_b = WW'(b); w_sub = sub;
        #1;
        model(WW, a, b, sub, er, ec, ev);
        chk(sub ? "R2" : "R1", "wide result", int'(w_res), er);
        chk(sub ? "R4" : "R3", "wide carry", int'(w_c), ec);
        chk(sub ? "R6" : "R5", "wide ovf", int'(w_v), ev);
    endtask

    initial begin
        int seed;
        n_sub = 1'b0; n_a = '0; n_b = '0;
        w_sub = 1'b0; w_a = '0; w_b = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "zero inputs result", int'(n_res), 0);
        chk("R3", "zero inputs carry", int'(n_c), 0);

        // R8 fixed examples
        run_narrow(7, 4, 1'b0);
        chk("R8", "7+4 result", int'(n_res), 11);
        chk("R8", "7+4 ovf", int'(n_v), 1);
        run_narrow(12, 10, 1'b0);
        chk("R8", "-4+-6 result", int'(n_res), 6);
        chk("R8", "-4+-6 ovf", int'(n_v), 1);

        // exhaustive narrow sweep
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < (1 << NW); a++)
                for (int b = 0; b < (1 << NW); b++)
                    run_narrow(a, b, s[0]);

        // wide boundaries
        run_wide(16'h7FFF, 1, 1'b0);
        run_wide(16'h8000, 16'h8000, 1'b0);
        run_wide(16'hFFFF, 1, 1'b0);
        run_wide(16'h8000, 1, 1'b1);
        run_wide(16'h7FFF, 16'hFFFF, 1'b1);
        run_wide(0, 16'h8000, 1'b1);
        run_wide(16'h1234, 16'h1234, 1'b1);

        // pseudo-random walk
        seed = 32'h1ACE;
        for (int k = 0; k < 2000; k++) begin
            int ra, rb;
            seed = seed * 1103515245 + 12345;
            ra = (seed >> 8) & 16'hFFFF;
            seed = seed * 1103515245 + 12345;
            rb = (seed >> 8) & 16'hFFFF;
            run_wide(ra, rb, k[0]);
        end

        finish_run();
    end

    initial begin
        int cyc;
        for (cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
        finish_run();
    end

endmodule